// File: doc/BRIEF.md
# Wavefront Slot and Register Allocator

This block decides whether a new wavefront can be made resident on a SIMD unit. Each SIMD has three limited resources: a small set of wavefront slots, a scalar register budget and a vector register budget. A launch request names the target SIMD and gives the number of scalar and vector registers the wavefront needs. The allocator looks for a free slot and for a contiguous free range in each register file. It then answers with a slot index and a base address in each file, or it refuses the request.

Register space is tracked in granules of eight registers. Each SIMD keeps a free bitmap per register file and searches it first-fit, from the lowest address upwards. Because every resident wavefront holds its own ranges, the number of wavefronts a SIMD can host drops as each one asks for more registers. A wavefront stays on the SIMD that granted it until a release names that SIMD and slot. The release returns the slot and both ranges at once.

Requests use a valid/ready handshake. A response appears a fixed number of cycles after acceptance. A release that lands in the same cycle as an allocation decision is applied first, so the allocation can reuse what was just freed.

Top module: `wave_admit`

## Requirements
- R1: After reset `req_ready` is high from the first clock edge on. Every accepted request (`req_valid` and `req_ready` high at a rising edge) produces exactly one response, with `rsp_valid` high for one cycle two rising edges after acceptance. `rsp_grant` and `rsp_error` are only high together with `rsp_valid`.
- R2: A request that asks for more than 104 scalar registers, for zero vector registers or for more than 256 vector registers is refused with `rsp_error` high and `rsp_grant` low.
- R3: A SIMD holds at most 10 resident wavefronts. A request to a SIMD with all slots taken is refused with `rsp_grant` low and `rsp_error` low. A grant gives the lowest free slot index.
- R4: Scalar registers are handed out from a 512-entry file. A count is rounded up to a multiple of 8. The base is the lowest multiple of 8 that starts a free run long enough for the request. A scalar request of 0 gets base 0 and uses no space.
- R5: Vector registers are handed out from a 256-entry file in the same rounded, first-fit way. A request is refused when no contiguous free run is long enough, even if the total free space would be enough.
- R6: Each SIMD has its own slots and register files. An allocation or release on one SIMD does not change what another SIMD can grant.
- R7: A release (`rel_valid` with a SIMD and a slot) frees that slot and both of its register ranges in one cycle. The freed resources can be granted by the next decision. A release of a slot that is not resident has no effect.
- R8: When a release takes effect in the same cycle as an allocation decision, the release is applied first and the decision sees the freed resources.
- R9: After reset no wavefront is resident and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Launch request present |
| req_ready | output | 1 | Allocator can take a request |
| req_simd | input | 1 | Target SIMD index |
| req_sregs | input | 10 | Scalar registers wanted |
| req_vregs | input | 9 | Vector registers wanted |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_grant | output | 1 | Request admitted |
| rsp_error | output | 1 | Request malformed and refused |
| rsp_slot | output | 4 | Granted slot index |
| rsp_sbase | output | 9 | Granted scalar base address |
| rsp_vbase | output | 8 | Granted vector base address |
| rel_valid | input | 1 | Release a resident wavefront |
| rel_simd | input | 1 | SIMD of the released wavefront |
| rel_slot | input | 4 | Slot of the released wavefront |

## Verification
The bench uses the default parameters: two SIMDs, ten slots, 512 scalar and 256 vector registers, a per-wavefront scalar cap of 104 and 8-register granules. With these values a short run can fill every slot with small wavefronts. It can also use up the scalar file with four maximal requests and the vector file with one full-width request. It can split the vector file into holes to show that first-fit refuses a request that only fits by total size. With two SIMDs the bench can show that a full SIMD does not block its neighbour, and it can time a release into the decision cycle of a request to a full SIMD.

// File: rtl/wa_pkg.sv
// Package: shared helpers for the wavefront allocator.
// Assumes granule sizes are positive.
package wa_pkg;

    // Number of granules needed to hold n registers (round up).
    function automatic int unsigned granules(input int unsigned n, input int unsigned g);
        return (n + g - 1) / g;
    endfunction

endpackage

// File: rtl/wa_first_fit.sv
// wa_first_fit: finds the lowest index that starts a run of at least `need`
// consecutive set bits in `free_map`. A need of zero matches index 0.
// Purely combinational; assumes need <= N.
module wa_first_fit #(
    parameter int N = 64
) (
    input  logic [N-1:0]              free_map,
    input  logic [$clog2(N+1)-1:0]    need,
    output logic                      found,
    output logic [$clog2(N)-1:0]      base
);
    localparam int CW = $clog2(N + 1);
    localparam int IW = $clog2(N);

    logic [CW-1:0] run [N+1];

    // Length of the free run that starts at each index, built from the top.
    always_comb begin
        run[N] = '0;
        for (int i = N - 1; i >= 0; i--) begin
            run[i] = free_map[i] ? CW'(run[i+1] + CW'(1)) : '0;
        end
    end

    // Pick the lowest start whose run covers the need.
    always_comb begin
        found = 1'b0;
        base  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (run[i] >= need) begin
                found = 1'b1;
                base  = IW'(i);
            end
        end
    end

endmodule

// File: rtl/wa_simd_pool.sv
// wa_simd_pool: resource state of one SIMD: slot occupancy, scalar and
// vector granule free maps, and the ranges held by each slot.
// A release is folded in before the search, so an allocation committed in
// the same cycle sees the freed resources. Assumes commit is only raised
// when fit is high.
module wa_simd_pool #(
    parameter int SLOTS = 10,
    parameter int SG    = 64,
    parameter int VG    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rel_en,
    input  logic [$clog2(SLOTS)-1:0]  rel_slot,
    input  logic [$clog2(SG+1)-1:0]   s_need,
    input  logic [$clog2(VG+1)-1:0]   v_need,
    input  logic                      commit,
    output logic                      fit,
    output logic [$clog2(SLOTS)-1:0]  slot,
    output logic [$clog2(SG)-1:0]     s_base,
    output logic [$clog2(VG)-1:0]     v_base
);
    localparam int SLW = $clog2(SLOTS);

    logic [SLOTS-1:0] busy, busy_n;
    logic [SG-1:0]    s_free, s_free_n, s_new;
    logic [VG-1:0]    v_free, v_free_n, v_new;
    logic [SG-1:0]    s_mask [SLOTS];
    logic [VG-1:0]    v_mask [SLOTS];
    logic             rel_hit;
    logic             slot_ok, s_ok, v_ok;

    // Apply a pending release to produce the state the search works on.
    always_comb begin
        rel_hit  = rel_en && (int'(rel_slot) < SLOTS) && busy[rel_slot];
        busy_n   = busy;
        s_free_n = s_free;
        v_free_n = v_free;
        if (rel_hit) begin
            busy_n[rel_slot] = 1'b0;
            s_free_n         = s_free | s_mask[rel_slot];
            v_free_n         = v_free | v_mask[rel_slot];
        end
    end

    wa_first_fit #(.N(SLOTS)) u_slot_ff (
        .free_map (~busy_n),
        .need     ($clog2(SLOTS+1)'(1)),
        .found    (slot_ok),
        .base     (slot)
    );

    wa_first_fit #(.N(SG)) u_sreg_ff (
        .free_map (s_free_n),
        .need     (s_need),
        .found    (s_ok),
        .base     (s_base)
    );

    wa_first_fit #(.N(VG)) u_vreg_ff (
        .free_map (v_free_n),
        .need     (v_need),
        .found    (v_ok),
        .base     (v_base)
    );

    assign fit = slot_ok && s_ok && v_ok;

    // Granule masks of the ranges a commit would claim.
    always_comb begin
        for (int j = 0; j < SG; j++)
            s_new[j] = (j >= int'(s_base)) && (j < int'(s_base) + int'(s_need));
        for (int j = 0; j < VG; j++)
            v_new[j] = (j >= int'(v_base)) && (j < int'(v_base) + int'(v_need));
    end

    // Update occupancy and free maps with the release, then the commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= '0;
            s_free <= '1;
            v_free <= '1;
            for (int k = 0; k < SLOTS; k++) begin
                s_mask[k] <= '0;
                v_mask[k] <= '0;
            end
        end else begin
            busy   <= busy_n;
            s_free <= s_free_n;
            v_free <= v_free_n;
            if (commit) begin
                busy[slot]   <= 1'b1;
                s_free       <= s_free_n & ~s_new;
                v_free       <= v_free_n & ~v_new;
                s_mask[slot] <= s_new;
                v_mask[slot] <= v_new;
            end
        end
    end

    logic unused_w;
    assign unused_w = ^SLW;

endmodule

// File: rtl/wave_admit.sv
// wave_admit: admits wavefronts onto SIMD units. A request is captured in
// stage one (granule counts and validity are worked out there). It is
// decided in stage two against the target SIMD's pool, and the registered
// response follows two edges after acceptance. Assumes GRAN divides both
// register budgets and NUM_SIMD is a power of two.
module wave_admit #(
    parameter int NUM_SIMD = 2,
    parameter int SLOTS    = 10,
    parameter int SREGS    = 512,
    parameter int VREGS    = 256,
    parameter int SCAP     = 104,
    parameter int GRAN     = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  req_valid,
    output logic                                  req_ready,
    input  logic [(NUM_SIMD>1?$clog2(NUM_SIMD):1)-1:0] req_simd,
    input  logic [$clog2(SREGS+1)-1:0]            req_sregs,
    input  logic [$clog2(VREGS+1)-1:0]            req_vregs,
    output logic                                  rsp_valid,
    output logic                                  rsp_grant,
    output logic                                  rsp_error,
    output logic [$clog2(SLOTS)-1:0]              rsp_slot,
    output logic [$clog2(SREGS)-1:0]              rsp_sbase,
    output logic [$clog2(VREGS)-1:0]              rsp_vbase,
    input  logic                                  rel_valid,
    input  logic [(NUM_SIMD>1?$clog2(NUM_SIMD):1)-1:0] rel_simd,
    input  logic [$clog2(SLOTS)-1:0]              rel_slot
);
    localparam int SIMD_W  = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1;
    localparam int SG      = SREGS / GRAN;
    localparam int VG      = VREGS / GRAN;
    localparam int SLW     = $clog2(SLOTS);
    localparam int SCW     = $clog2(SG + 1);
    localparam int VCW     = $clog2(VG + 1);
    localparam int SIW     = $clog2(SG);
    localparam int VIW     = $clog2(VG);
    localparam int SBW     = $clog2(SREGS);
    localparam int VBW     = $clog2(VREGS);

    logic              acc;
    logic              s1_valid, s1_bad;
    logic [SIMD_W-1:0] s1_simd;
    logic [SCW-1:0]    s1_sgran;
    logic [VCW-1:0]    s1_vgran;

    logic           fit_v    [NUM_SIMD];
    logic [SLW-1:0] slot_v   [NUM_SIMD];
    logic [SIW-1:0] sbase_v  [NUM_SIMD];
    logic [VIW-1:0] vbase_v  [NUM_SIMD];
    logic           commit_v [NUM_SIMD];

    logic           fit_sel;
    logic [SLW-1:0] slot_sel;
    logic [SIW-1:0] sbase_sel;
    logic [VIW-1:0] vbase_sel;
    logic           grant_now;

    assign acc = req_valid && req_ready;

    // Ready rises on the first edge after reset and stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) req_ready <= 1'b0;
        else        req_ready <= 1'b1;
    end

    // Stage one: capture the request as granule counts plus a malformed flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_bad   <= 1'b0;
            s1_simd  <= '0;
            s1_sgran <= '0;
            s1_vgran <= '0;
        end else begin
            s1_valid <= acc;
            if (acc) begin
                s1_simd  <= req_simd;
                s1_bad   <= (int'(req_sregs) > SCAP) || (req_vregs == '0) ||
                            (int'(req_vregs) > VREGS);
                s1_sgran <= SCW'(wa_pkg::granules(int'(req_sregs), GRAN));
                s1_vgran <= VCW'(wa_pkg::granules(int'(req_vregs), GRAN));
            end
        end
    end

    // One resource pool per SIMD; only the targeted pool may commit.
    for (genvar k = 0; k < NUM_SIMD; k++) begin : g_pool
        assign commit_v[k] = s1_valid && !s1_bad && (int'(s1_simd) == k) && fit_v[k];

        wa_simd_pool #(.SLOTS(SLOTS), .SG(SG), .VG(VG)) u_pool (
            .clk      (clk),
            .rst_n    (rst_n),
            .rel_en   (rel_valid && (int'(rel_simd) == k)),
            .rel_slot (rel_slot),
            .s_need   (s1_sgran),
            .v_need   (s1_vgran),
            .commit   (commit_v[k]),
            .fit      (fit_v[k]),
            .slot     (slot_v[k]),
            .s_base   (sbase_v[k]),
            .v_base   (vbase_v[k])
        );
    end

    // Select the answer of the targeted SIMD.
    always_comb begin
        fit_sel   = fit_v[s1_simd];
        slot_sel  = slot_v[s1_simd];
        sbase_sel = sbase_v[s1_simd];
        vbase_sel = vbase_v[s1_simd];
        grant_now = s1_valid && !s1_bad && fit_sel;
    end

    // Stage two: register the response; addresses are granule index times GRAN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_error <= 1'b0;
            rsp_slot  <= '0;
            rsp_sbase <= '0;
            rsp_vbase <= '0;
        end else begin
            rsp_valid <= s1_valid;
            rsp_grant <= grant_now;
            rsp_error <= s1_valid && s1_bad;
            rsp_slot  <= grant_now ? slot_sel : '0;
            rsp_sbase <= grant_now ? SBW'(int'(sbase_sel) * GRAN) : '0;
            rsp_vbase <= grant_now ? VBW'(int'(vbase_sel) * GRAN) : '0;
        end
    end

endmodule

// File: rtl/wave_admit_chk.sv
// wave_admit_chk: port-level properties of the allocator, bound to it.
// Assumes the request fields are held by the accepting edge only, so the
// values two edges back belong to the request being answered.
module wave_admit_chk #(
    parameter int SLOTS = 10,
    parameter int SREGS = 512,
    parameter int VREGS = 256,
    parameter int SCAP  = 104,
    parameter int SIMD_W = 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic [$clog2(SREGS+1)-1:0] req_sregs,
    input logic [$clog2(VREGS+1)-1:0] req_vregs,
    input logic                       rsp_valid,
    input logic                       rsp_grant,
    input logic                       rsp_error,
    input logic [$clog2(SLOTS)-1:0]   rsp_slot,
    input logic [$clog2(SREGS)-1:0]   rsp_sbase,
    input logic [$clog2(VREGS)-1:0]   rsp_vbase
);
    // R1: one response, exactly two edges after each acceptance.
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (rsp_valid == $past(req_valid && req_ready, 2)));

    // R1: outcome flags only with a valid response, never both at once.
    p_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_grant || rsp_error) |-> (rsp_valid && !(rsp_grant && rsp_error)));

    // R2: malformed requests are refused with the error flag.
    p_bad_rejected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && ((int'($past(req_sregs, 2)) > SCAP) || ($past(req_vregs, 2) == '0)))
        |-> (rsp_error && !rsp_grant));

    // R3: a granted slot index lies inside the slot range.
    p_slot_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_grant |-> (int'(rsp_slot) < SLOTS));

    // R4: a granted scalar range ends inside the scalar file.
    p_sregs_fit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_grant |-> (int'(rsp_sbase) + int'($past(req_sregs, 2)) <= SREGS));

    // R5: a granted vector range ends inside the vector file.
    p_vregs_fit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_grant |-> (int'(rsp_vbase) + int'($past(req_vregs, 2)) <= VREGS));

endmodule

bind wave_admit wave_admit_chk #(
    .SLOTS (SLOTS),
    .SREGS (SREGS),
    .VREGS (VREGS),
    .SCAP  (SCAP),
    .SIMD_W(SIMD_W)
) u_chk (.*);

// File: tb/sim_wave_admit.sv
// sim_wave_admit: scoreboard bench. The driver pushes the expected outcome
// of each request; the monitor pops and compares on every valid response.
module sim_wave_admit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [0:0] req_simd = '0;
    logic [9:0] req_sregs = '0;
    logic [8:0] req_vregs = '0;
    logic       rsp_valid, rsp_grant, rsp_error;
    logic [3:0] rsp_slot;
    logic [8:0] rsp_sbase;
    logic [7:0] rsp_vbase;
    logic       rel_valid = 1'b0;
    logic [0:0] rel_simd = '0;
    logic [3:0] rel_slot = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        bit    ok;
        bit    err;
        int    slot;
        int    sb;
        int    vb;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    wave_admit u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_simd(req_simd),
        .req_sregs(req_sregs), .req_vregs(req_vregs),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_error(rsp_error),
        .rsp_slot(rsp_slot), .rsp_sbase(rsp_sbase), .rsp_vbase(rsp_vbase),
        .rel_valid(rel_valid), .rel_simd(rel_simd), .rel_slot(rel_slot)
    );

    task automatic check(input bit cond, input string tag, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Driver: present one request for one cycle and push its expected outcome.
    task automatic send(input int simd, input int s, input int v, input bit ok,
                        input bit err, input int slot, input int sb, input int vb,
                        input string tag);
        exp_t e;
        e.ok = ok; e.err = err; e.slot = slot; e.sb = sb; e.vb = vb; e.tag = tag;
        sb_q.push_back(e);
        req_valid = 1'b1;
        req_simd  = 1'(simd);
        req_sregs = 10'(s);
        req_vregs = 9'(v);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic release_slot(input int simd, input int slot);
        rel_valid = 1'b1;
        rel_simd  = 1'(simd);
        rel_slot  = 4'(slot);
        @(negedge clk);
        rel_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare every response against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R1", "unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(rsp_grant == e.ok, e.tag, "grant", int'(rsp_grant), int'(e.ok));
                check(rsp_error == e.err, e.tag, "error", int'(rsp_error), int'(e.err));
                if (e.ok) begin
                    check(int'(rsp_slot) == e.slot, e.tag, "slot", int'(rsp_slot), e.slot);
                    check(int'(rsp_sbase) == e.sb, e.tag, "sbase", int'(rsp_sbase), e.sb);
                    check(int'(rsp_vbase) == e.vb, e.tag, "vbase", int'(rsp_vbase), e.vb);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: nothing resident, no response; R1: ready after the first edge.
        check(rsp_valid == 1'b0, "R9", "rsp_valid after reset", int'(rsp_valid), 0);
        check(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);

        // R4 rounding, R2 malformed requests.
        send(0, 5,   8,   1, 0, 0, 0, 0, "R4 round 5->8");
        send(0, 104, 8,   1, 0, 1, 8, 8, "R4 cap-size grant");
        send(0, 105, 8,   0, 1, 0, 0, 0, "R2 scalar over cap");
        send(0, 8,   0,   0, 1, 0, 0, 0, "R2 zero vector");
        send(0, 8,   257, 0, 1, 0, 0, 0, "R2 vector over file");
        idle(3);
        release_slot(0, 0);
        release_slot(0, 1);
        release_slot(0, 7); // R7: not resident, no effect
        idle(2);

        // R3: ten slots, the eleventh is refused without error.
        for (int i = 0; i < 10; i++)
            send(0, 8, 8, 1, 0, i, 8*i, 8*i, "R3 fill slots");
        send(0, 8, 8, 0, 0, 0, 0, 0, "R3 eleventh refused");
        idle(3);
        for (int i = 0; i < 10; i++) release_slot(0, i);
        idle(2);

        // R4: scalar budget; R7: freed space reused from base 0.
        for (int i = 0; i < 4; i++)
            send(0, 104, 8, 1, 0, i, 104*i, 8*i, "R4 R7 scalar fill");
        send(0, 104, 8, 0, 0, 0, 0,   0,  "R4 scalar exhausted");
        send(0, 96,  8, 1, 0, 4, 416, 32, "R4 scalar tail fits");
        idle(3);
        for (int i = 0; i < 5; i++) release_slot(0, i);
        idle(2);

        // R5 full vector file; R6 other SIMD unaffected.
        send(0, 0, 256, 1, 0, 0, 0, 0, "R5 whole vector file");
        send(0, 0, 8,   0, 0, 0, 0, 0, "R5 vector exhausted");
        send(1, 0, 8,   1, 0, 0, 0, 0, "R6 other SIMD grants");
        idle(3);
        release_slot(0, 0);
        release_slot(1, 0);
        idle(2);

        // R5 first-fit with holes; R7 hole reused.
        send(0, 0, 64, 1, 0, 0, 0, 0,   "R5 block A");
        send(0, 0, 64, 1, 0, 1, 0, 64,  "R5 block B");
        send(0, 0, 64, 1, 0, 2, 0, 128, "R5 block C");
        idle(3);
        release_slot(0, 1);
        send(0, 0, 128, 0, 0, 0, 0, 0,  "R5 no contiguous run");
        send(0, 0, 32,  1, 0, 1, 0, 64, "R5 R7 first hole reused");
        idle(3);
        release_slot(0, 0);
        release_slot(0, 1);
        release_slot(0, 2);
        idle(2);

        // R8: release in the decision cycle of a request to a full SIMD.
        for (int i = 0; i < 10; i++)
            send(1, 8, 8, 1, 0, i, 8*i, 8*i, "R8 fill SIMD1");
        send(1, 8, 8, 0, 0, 0, 0, 0, "R3 SIMD1 full");
        idle(3);
        send(1, 8, 8, 1, 0, 3, 24, 24, "R8 release first");
        release_slot(1, 3);
        idle(4);

        check(sb_q.size() == 0, "R1", "responses outstanding", sb_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule